// File: doc/BRIEF.md
# Sleep-Mode Sensor Coprocessor Core

This block is a small sequencer-style processor that keeps working while the main processors of the chip are asleep. It fetches fixed 32-bit instructions from a word-addressed slow memory and works on four 16-bit general registers, R0 to R3. It runs register and immediate ALU operations, loads and stores to the slow memory, relative branches that compare R0 against an immediate, absolute jumps that are unconditional or conditional on the flags of the last ALU operation, a delay, a halt, and an end instruction that can wake the main CPU.

A host places a program in the slow memory, presents an entry address and pulses the start input. The core then runs until a halt or end instruction. At that point it reports halted and, for an end with its wake bit set, raises a wakeup pulse lasting one clock. The memory port is synchronous: read data returns one cycle after the request. Each instruction runs through a fixed sequence of fetch, execute and, for loads only, a memory-return state. ALU operations, stores, branches and jumps take two cycles and loads take three.

Top module: `snsq_core`

## Requirements
- R1: After reset, halted_o is 1, wake_o is 0 and mem_req_o is 0. While halted, no memory request is issued.
- R2: Opcode bits [31:28] = 0 is the register form (dest [1:0], src1 [3:2], src2 [5:4]). Opcode 1 is the immediate form (dest [1:0], src [3:2], imm [19:4]). For both forms the operation code is in [27:25]: 0 add, 1 subtract, 2 AND, 3 OR, 4 move, 5 shift left, 6 shift right (logical). Move copies src1 in the register form and the immediate in the immediate form. A shift by 16 or more gives 0.
- R3: Every ALU instruction sets a zero flag when its 16-bit result is 0. It sets an overflow flag to the carry out of an add or the borrow of a subtract, and to 0 for all other operations. No other instruction changes the flags.
- R4: A load (opcode 2; dest [1:0], address register [3:2], offset [20:10]) reads the word at register + offset, modulo 2048. It writes only that word's low 16 bits into dest.
- R5: A store (opcode 3; value register [1:0], address register [3:2], offset [20:10]) writes, at register + offset, the word {5'b0, 11-bit word address of the store, 16-bit value}.
- R6: A relative branch (opcode 4) has immediate [15:0], compare bit [16], magnitude [23:17] and sign bit [24] (1 = backward). It jumps to its own address plus or minus the magnitude. It is taken when R0 < immediate (compare bit 0) or when R0 >= immediate (compare bit 1); otherwise execution continues at the next word.
- R7: An absolute jump (opcode 5) takes its target from [12:2], or from the low 11 bits of the register selected by [1:0] when bit [25] is 1. Its type [27:26] selects 0 always, 1 if the zero flag is set, 2 if the overflow flag is set.
- R8: A delay (opcode 6, count [15:0]) adds exactly count cycles to the run time and changes no register.
- R9: An end instruction (opcode 7) stops execution. When bit [0] is 1 it also gives one single-cycle wake_o pulse, in the cycle in which halted_o is first 1 again. A halt (opcode 8, or any unused opcode) stops execution with no wakeup.
- R10: A start_i pulse loads the PC from entry_i and clears halted_o. The next cycle fetches from that address. The PC wraps modulo 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; begins execution at entry_i |
| entry_i | input | 11 | Entry word address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | 11 | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| halted_o | output | 1 | Core is stopped |
| wake_o | output | 1 | One-cycle wakeup pulse to the main CPU |

## Verification
The hardest state to observe is the pair of ALU flags, because no port shows them directly. The bench makes them visible through the normal instruction stream. Each generated program runs a random ALU operation, stores its result, and then uses zero- and overflow-conditional jumps to choose between two immediate moves whose value is stored afterwards. Random operands are mixed with directed carry, borrow, equal-operand and oversized-shift cases, so that both the taken and the not-taken path of each conditional jump occur.

// File: rtl/snsq_pkg.sv
package snsq_pkg;
    localparam int INSN_W = 32;
    localparam int PC_W   = 11;
    localparam int DW     = 16;
    localparam int NREG   = 4;
    localparam int RI_W   = $clog2(NREG);

    typedef enum logic [3:0] {
        OP_ALUR = 4'd0, OP_ALUI = 4'd1, OP_LD  = 4'd2, OP_ST   = 4'd3,
        OP_BR   = 4'd4, OP_JMP  = 4'd5, OP_DLY = 4'd6, OP_END  = 4'd7,
        OP_HALT = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        AL_ADD = 3'd0, AL_SUB = 3'd1, AL_AND = 3'd2, AL_OR = 3'd3,
        AL_MOV = 3'd4, AL_LSH = 3'd5, AL_RSH = 3'd6
    } alu_e;

    typedef enum logic [1:0] {
        J_ALWAYS = 2'd0, J_ZERO = 2'd1, J_OVF = 2'd2
    } jmp_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0, S_FETCH = 3'd1, S_EXEC = 3'd2, S_MEM = 3'd3, S_DELAY = 3'd4
    } state_e;
endpackage

// File: rtl/snsq_alu.sv
module snsq_alu #(
    parameter int W = 16
) (
    input  logic [2:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         ovf_o
);
    import snsq_pkg::*;

    logic [W:0] wide;

    always_comb begin
        wide  = '0;
        ovf_o = 1'b0;
        res_o = '0;
        case (sel_i)
            AL_ADD: begin
                wide  = {1'b0, a_i} + {1'b0, b_i};
                res_o = wide[W-1:0];
                ovf_o = wide[W];
            end
            AL_SUB: begin
                res_o = a_i - b_i;
                ovf_o = (a_i < b_i);
            end
            AL_AND:  res_o = a_i & b_i;
            AL_OR:   res_o = a_i | b_i;
            AL_MOV:  res_o = b_i;
            AL_LSH:  res_o = a_i << b_i;
            AL_RSH:  res_o = a_i >> b_i;
            default: res_o = '0;
        endcase
        zero_o = (res_o == '0);
    end
endmodule

// File: rtl/snsq_nextpc.sv
module snsq_nextpc
    import snsq_pkg::*;
(
    input  logic [PC_W-1:0]   pc_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DW-1:0]     r0_i,
    input  logic [PC_W-1:0]   rtgt_i,
    input  logic              zf_i,
    input  logic              of_i,
    output logic [PC_W-1:0]   npc_o
);
    localparam int MAG_W = 7;

    logic [PC_W-1:0] seq, tgt, mag;
    logic            taken, lt;

    always_comb begin
        seq   = pc_i + PC_W'(1);
        tgt   = seq;
        taken = 1'b0;
        mag   = {{(PC_W-MAG_W){1'b0}}, insn_i[23:17]};
        lt    = (r0_i < insn_i[15:0]);
        case (insn_i[31:28])
            OP_BR: begin
                taken = insn_i[16] ? !lt : lt;
                tgt   = insn_i[24] ? (pc_i - mag) : (pc_i + mag);
            end
            OP_JMP: begin
                tgt = insn_i[25] ? rtgt_i : insn_i[12:2];
                case (insn_i[27:26])
                    J_ALWAYS: taken = 1'b1;
                    J_ZERO:   taken = zf_i;
                    J_OVF:    taken = of_i;
                    default:  taken = 1'b0;
                endcase
            end
            default: taken = 1'b0;
        endcase
        npc_o = taken ? tgt : seq;
    end
endmodule

// File: rtl/snsq_core.sv
module snsq_core
    import snsq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PC_W-1:0]   entry_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [PC_W-1:0]   mem_addr_o,
    output logic [INSN_W-1:0] mem_wdata_o,
    input  logic [INSN_W-1:0] mem_rdata_i,
    output logic              halted_o,
    output logic              wake_o
);
    localparam int PAD_W = INSN_W - PC_W - DW;

    typedef struct packed {
        state_e                   st;
        logic [PC_W-1:0]          pc;
        logic [NREG-1:0][DW-1:0]  regs;
        logic                     zf;
        logic                     of;
        logic [RI_W-1:0]          ld_dst;
        logic [DLY_W-1:0]         dly;
        logic                     wake;
    } core_t;

    core_t q, d;

    // instruction fields, valid in S_EXEC
    logic [3:0]      op;
    logic [RI_W-1:0] f_d, f_s, f_t;
    logic [DW-1:0]   f_imm;
    logic [PC_W-1:0] f_off, maddr, npc;
    logic [DW-1:0]   alu_b, alu_res;
    logic            alu_z, alu_o;

    assign op    = mem_rdata_i[31:28];
    assign f_d   = mem_rdata_i[1:0];
    assign f_s   = mem_rdata_i[3:2];
    assign f_t   = mem_rdata_i[5:4];
    assign f_imm = mem_rdata_i[19:4];
    assign f_off = mem_rdata_i[20:10];
    assign maddr = q.regs[f_s][PC_W-1:0] + f_off;

    always_comb begin
        if (op == OP_ALUI)                          alu_b = f_imm;
        else if (mem_rdata_i[27:25] == AL_MOV)      alu_b = q.regs[f_s];
        else                                        alu_b = q.regs[f_t];
    end

    snsq_alu #(.W(DW)) u_alu (
        .sel_i (mem_rdata_i[27:25]),
        .a_i   (q.regs[f_s]),
        .b_i   (alu_b),
        .res_o (alu_res),
        .zero_o(alu_z),
        .ovf_o (alu_o)
    );

    snsq_nextpc u_npc (
        .pc_i  (q.pc),
        .insn_i(mem_rdata_i),
        .r0_i  (q.regs[0]),
        .rtgt_i(q.regs[f_d][PC_W-1:0]),
        .zf_i  (q.zf),
        .of_i  (q.of),
        .npc_o (npc)
    );

    always_comb begin
        d           = q;
        d.wake      = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.pc;
        mem_wdata_o = '0;
        case (q.st)
            S_FETCH: begin
                mem_req_o = 1'b1;
                d.st      = S_EXEC;
            end
            S_EXEC: begin
                d.pc = npc;
                d.st = S_FETCH;
                case (op)
                    OP_ALUR, OP_ALUI: begin
                        d.regs[f_d] = alu_res;
                        d.zf        = alu_z;
                        d.of        = alu_o;
                    end
                    OP_LD: begin
                        mem_req_o  = 1'b1;
                        mem_addr_o = maddr;
                        d.ld_dst   = f_d;
                        d.st       = S_MEM;
                    end
                    OP_ST: begin
                        mem_req_o   = 1'b1;
                        mem_we_o    = 1'b1;
                        mem_addr_o  = maddr;
                        mem_wdata_o = {{PAD_W{1'b0}}, q.pc, q.regs[f_d]};
                    end
                    OP_BR, OP_JMP: ;
                    OP_DLY: begin
                        if (mem_rdata_i[DLY_W-1:0] != '0) begin
                            d.dly = mem_rdata_i[DLY_W-1:0];
                            d.st  = S_DELAY;
                        end
                    end
                    OP_END: begin
                        d.st   = S_IDLE;
                        d.wake = mem_rdata_i[0];
                    end
                    default: d.st = S_IDLE;
                endcase
            end
            S_MEM: begin
                d.regs[q.ld_dst] = mem_rdata_i[DW-1:0];
                d.st             = S_FETCH;
            end
            S_DELAY: begin
                if (q.dly == DLY_W'(1)) d.st  = S_FETCH;
                else                    d.dly = q.dly - DLY_W'(1);
            end
            default: ;
        endcase
        if (start_i) begin
            d.pc = entry_i;
            d.st = S_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign halted_o = (q.st == S_IDLE);
    assign wake_o   = q.wake;
endmodule

// File: rtl/snsq_chk.sv
module snsq_chk
    import snsq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [PC_W-1:0]   entry_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [PC_W-1:0]   mem_addr_o,
    input logic [INSN_W-1:0] mem_wdata_o,
    input logic              halted_o,
    input logic              wake_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !mem_req_o);
    p_store_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_req_o && mem_wdata_o[31:27] == 5'd0));
    p_store_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_req_o) && (mem_wdata_o[26:16] == $past(mem_addr_o)));
    p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    p_wake_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> halted_o);
    p_start_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!halted_o && mem_req_o && !mem_we_o && mem_addr_o == $past(entry_i)));
endmodule

bind snsq_core snsq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .entry_i    (entry_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .halted_o   (halted_o),
    .wake_o     (wake_o)
);

// File: tb/snsq_core_tb.sv
module snsq_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] entry = '0;
    logic        req, we, halted, wake;
    logic [10:0] addr;
    logic [31:0] wdata, rdata;
    logic        tb_we = 1'b0;
    logic [10:0] tb_addr = '0;
    logic [31:0] tb_data = '0;
    logic [31:0] mem [2048];
    int          n_chk = 0, n_bad = 0, wake_cnt = 0;

    always #5 clk = ~clk;

    snsq_core u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .entry_i(entry),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
        .mem_rdata_i(rdata), .halted_o(halted), .wake_o(wake)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        else if (req) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
        if (wake) wake_cnt <= wake_cnt + 1;
    end

    // instruction builders
    function automatic logic [31:0] e_alur(input logic [2:0] s, input logic [1:0] dd, input logic [1:0] ss, input logic [1:0] tt);
        return {4'h0, s, 19'b0, tt, ss, dd};
    endfunction
    function automatic logic [31:0] e_alui(input logic [2:0] s, input logic [1:0] dd, input logic [1:0] ss, input logic [15:0] im);
        return {4'h1, s, 5'b0, im, ss, dd};
    endfunction
    function automatic logic [31:0] e_ld(input logic [1:0] dd, input logic [1:0] ss, input logic [10:0] off);
        return {4'h2, 7'b0, off, 6'b0, ss, dd};
    endfunction
    function automatic logic [31:0] e_st(input logic [1:0] v, input logic [1:0] ss, input logic [10:0] off);
        return {4'h3, 7'b0, off, 6'b0, ss, v};
    endfunction
    function automatic logic [31:0] e_br(input logic back, input logic [6:0] mag, input logic ge, input logic [15:0] im);
        return {4'h4, 3'b0, back, mag, ge, im};
    endfunction
    function automatic logic [31:0] e_jmp(input logic [1:0] ty, input logic isreg, input logic [10:0] a, input logic [1:0] r);
        return {4'h5, ty, isreg, 12'b0, a, r};
    endfunction
    function automatic logic [31:0] e_dly(input logic [15:0] n);
        return {4'h6, 12'b0, n};
    endfunction
    function automatic logic [31:0] e_end(input logic w);
        return {4'h7, 27'b0, w};
    endfunction
    function automatic logic [31:0] e_halt();
        return {4'h8, 28'b0};
    endfunction
    function automatic logic [31:0] stw(input logic [10:0] pc, input logic [15:0] v);
        return {5'b0, pc, v};
    endfunction

    // reference ALU: {ovf, result}
    function automatic logic [16:0] m_alu(input logic [2:0] s, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] w;
        case (s)
            3'd0: w = {1'b0, a} + {1'b0, b};
            3'd1: w = {(a < b), a - b};
            3'd2: w = {1'b0, a & b};
            3'd3: w = {1'b0, a | b};
            3'd4: w = {1'b0, b};
            3'd5: w = {1'b0, (b >= 16) ? 16'd0 : a << b};
            default: w = {1'b0, (b >= 16) ? 16'd0 : a >> b};
        endcase
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [10:0] a, input logic [31:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_data = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic run(input logic [10:0] ep, output int cyc);
        @(negedge clk);
        start = 1'b1; entry = ep;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 5000) chk("R9 run timeout", 32'd1, 32'd0);
    endtask

    task automatic alu_case(input logic [2:0] s, input logic immf, input logic [15:0] a, input logic [15:0] b);
        logic [2:0] j;
        logic [16:0] r;
        int c, w0;
        logic [31:0] op;
        j  = 3'd0;
        op = immf ? e_alui(s, 2'd3, 2'd1, b) : e_alur(s, 2'd3, 2'd1, 2'd2);
        r  = m_alu(s, a, (s == 3'd4 && !immf) ? a : b);
        poke(0,  e_alui(3'd4, 2'd0, 2'd0, 16'd100));
        poke(1,  e_alui(3'd4, 2'd1, 2'd0, a));
        poke(2,  e_alui(3'd4, 2'd2, 2'd0, b));
        poke(3,  op);
        poke(4,  e_st(2'd3, 2'd0, 11'd0));
        poke(5,  e_jmp(2'd1, 1'b0, 11'd8, 2'd0));
        poke(6,  e_alui(3'd4, 2'd3, 2'd0, 16'd0));
        poke(7,  e_jmp(2'd0, 1'b0, 11'd9, 2'd0));
        poke(8,  e_alui(3'd4, 2'd3, 2'd0, 16'd1));
        poke(9,  e_st(2'd3, 2'd0, 11'd1));
        poke(10, op);
        poke(11, e_jmp(2'd2, 1'b0, 11'd14, 2'd0));
        poke(12, e_alui(3'd4, 2'd3, 2'd0, 16'd0));
        poke(13, e_jmp(2'd0, 1'b0, 11'd15, 2'd0));
        poke(14, e_alui(3'd4, 2'd3, 2'd0, 16'd2));
        poke(15, e_st(2'd3, 2'd0, 11'd2));
        poke(16, e_end(1'b1));
        w0 = wake_cnt;
        run(11'd0, c);
        @(negedge clk);
        chk("R2 alu result+R5 store word", mem[100], stw(11'd4, r[15:0]));
        chk("R3 zero flag via R7 zero jump", mem[101], stw(11'd9, {15'b0, r[15:0] == 16'd0}));
        chk("R3 overflow flag via R7 ovf jump", mem[102], stw(11'd15, r[16] ? 16'd2 : 16'd0));
        chk("R9 end with wake pulses once", wake_cnt - w0, 32'd1);
        if (j != 0) $display("unused");
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int c0, c1, w0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk("R1 halted after reset", {31'b0, halted}, 32'd1);
        chk("R1 no wake after reset", {31'b0, wake}, 32'd0);
        chk("R1 no request after reset", {31'b0, req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle stays quiet", {30'b0, req, halted}, 32'd1);

        // directed ALU corners
        alu_case(3'd0, 1'b0, 16'hFFFF, 16'h0001);  // carry, zero
        alu_case(3'd1, 1'b0, 16'd3, 16'd5);        // borrow
        alu_case(3'd1, 1'b1, 16'd7, 16'd7);        // zero, no borrow
        alu_case(3'd5, 1'b1, 16'h00F0, 16'd16);    // shift out
        alu_case(3'd4, 1'b0, 16'h1234, 16'h0);     // reg move copies src1
        alu_case(3'd6, 1'b0, 16'h8000, 16'd15);
        for (int i = 0; i < 40; i++) begin
            logic [2:0] s;
            logic [15:0] a, b;
            s = 3'($urandom % 7);
            a = 16'($urandom);
            b = 16'($urandom);
            if (s == 3'd5 || s == 3'd6) b = 16'($urandom % 20);
            if (i % 5 == 0) b = a;
            alu_case(s, 1'($urandom), a, b);
        end

        // R4 load keeps only low half; halt gives no wake
        poke(200, 32'hABCD_1234);
        poke(20, e_alui(3'd4, 2'd0, 2'd0, 16'd190));
        poke(21, e_ld(2'd1, 2'd0, 11'd10));
        poke(22, e_alui(3'd4, 2'd2, 2'd0, 16'd430));
        poke(23, e_st(2'd1, 2'd2, 11'd0));
        poke(24, e_halt());
        w0 = wake_cnt;
        run(11'd20, c0);
        @(negedge clk);
        chk("R4 load low 16 bits", mem[430], stw(11'd23, 16'h1234));
        chk("R9 halt gives no wake", wake_cnt - w0, 32'd0);

        // R6 relative branches
        poke(40, e_alui(3'd4, 2'd0, 2'd0, 16'd0));
        poke(41, e_alui(3'd4, 2'd1, 2'd0, 16'd0));
        poke(42, e_alui(3'd0, 2'd1, 2'd1, 16'd3));
        poke(43, e_alui(3'd0, 2'd0, 2'd0, 16'd1));
        poke(44, e_br(1'b1, 7'd2, 1'b0, 16'd5));
        poke(45, e_alui(3'd4, 2'd2, 2'd0, 16'd300));
        poke(46, e_st(2'd1, 2'd2, 11'd0));
        poke(47, e_br(1'b0, 7'd2, 1'b1, 16'd0));
        poke(48, e_alui(3'd4, 2'd1, 2'd0, 16'h77));
        poke(49, e_st(2'd1, 2'd2, 11'd1));
        poke(50, e_end(1'b0));
        w0 = wake_cnt;
        run(11'd40, c0);
        @(negedge clk);
        chk("R6 backward branch while R0 less", mem[300], stw(11'd46, 16'd15));
        chk("R6 forward branch on R0 ge", mem[301], stw(11'd49, 16'd15));
        chk("R9 end without wake bit", wake_cnt - w0, 32'd0);

        // R7 register jump
        poke(70, e_alui(3'd4, 2'd2, 2'd0, 16'd80));
        poke(71, e_jmp(2'd0, 1'b1, 11'd0, 2'd2));
        poke(72, e_alui(3'd4, 2'd1, 2'd0, 16'd1));
        poke(80, e_alui(3'd4, 2'd1, 2'd0, 16'd9));
        poke(81, e_alui(3'd4, 2'd0, 2'd0, 16'd410));
        poke(82, e_st(2'd1, 2'd0, 11'd0));
        poke(83, e_end(1'b1));
        run(11'd70, c0);
        @(negedge clk);
        chk("R7 jump via register", mem[410], stw(11'd82, 16'd9));

        // R8 delay
        poke(60, e_alui(3'd4, 2'd3, 2'd0, 16'h5A5A));
        poke(61, e_dly(16'd0));
        poke(62, e_alui(3'd4, 2'd0, 2'd0, 16'd400));
        poke(63, e_st(2'd3, 2'd0, 11'd0));
        poke(64, e_halt());
        run(11'd60, c0);
        poke(61, e_dly(16'd25));
        run(11'd60, c1);
        chk("R8 delay 25 extra cycles", 32'(c1 - c0), 32'd25);
        poke(61, e_dly(16'd1));
        run(11'd60, c1);
        chk("R8 delay 1 extra cycle", 32'(c1 - c0), 32'd1);
        @(negedge clk);
        chk("R8 delay keeps registers", mem[400], stw(11'd63, 16'h5A5A));

        // R10 entry point and PC wrap
        poke(2046, e_alui(3'd4, 2'd0, 2'd0, 16'd420));
        poke(2047, e_alui(3'd4, 2'd1, 2'd0, 16'h33));
        poke(0, e_st(2'd1, 2'd0, 11'd0));
        poke(1, e_end(1'b1));
        run(11'd2046, c0);
        @(negedge clk);
        chk("R10 PC wraps to word 0", mem[420], stw(11'd0, 16'h33));
        chk("R10 halted after run", {31'b0, halted}, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule